// File: doc/BRIEF.md
# Parallel LCD Bus Cycle Engine

This block runs single register accesses on the parallel pins of a character-LCD module. It drives the register select, the read/write direction, the enable strobe and the data lines. A host hands it one request at a time through a valid/ready handshake. There are four request kinds: instruction write, data write, status read and data read. The block then runs one enable strobe on the full 8-bit bus, or two strobes when the narrow 4-bit bus on the upper data lines is chosen. On the narrow bus the engine splits each byte into two nibbles, or merges the two nibbles it reads back into one byte.

All strobe timing is set by parameters counted in system clocks. These are the control setup before the enable rises, the enable-high width, the hold after it falls, and the minimum spacing between rising edges. The block also owns the output enable of the data lines. It never drives them while the module is in read direction. A completed read returns the byte, plus a busy/address view of that same byte, in a one-cycle response pulse.

Top module: `lcd_bus_engine`

## Requirements
- R1: After reset the strobe, the direction line and the data output enable are low, `req_ready` is high and `rsp_valid` is low.
- R2: `req_kind` bit 0 sets the register select line and bit 1 sets the direction line (1 = read). Both hold that value, unchanged, through every strobe of the request.
- R3: On the 8-bit bus a write uses exactly one strobe, with the whole byte on `lcd_db_out[7:0]` and `lcd_db_oe` high.
- R4: On the 4-bit bus a write uses exactly two strobes. The first carries bits 7:4 of the byte and the second carries bits 3:0, both on `lcd_db_out[7:4]`, with `lcd_db_out[3:0]` at zero.
- R5: A read samples the data lines in the last clock in which the strobe is high. On the 8-bit bus the byte is `lcd_db_in[7:0]`. On the 4-bit bus bits 7:4 of the result come from `lcd_db_in[7:4]` at the first strobe and bits 3:0 from `lcd_db_in[7:4]` at the second. The response gives `rsp_data` as that byte, `rsp_busy` as its bit 7 and `rsp_addr` as its bits 6:0.
- R6: The select and direction lines are stable for at least SETUP_CYC clocks before each rising edge of the strobe.
- R7: Each strobe stays high for exactly HIGH_CYC clocks.
- R8: The select line, the direction line and the driven write data stay unchanged for at least HOLD_CYC clocks after each falling edge of the strobe. Write data also does not change while the strobe is high.
- R9: Two rising edges of the strobe are at least CYCLE_CYC clocks apart, both within one request and across requests.
- R10: `lcd_db_oe` is never high while the direction line is high. It is low in the clock before the direction line rises, and rises only in a clock after which the direction line was already low.
- R11: `req_ready` is low from the clock after a request is accepted until the request completes. While it is low, `req_valid`, `req_kind`, `req_wdata` and `bus_4bit` have no effect. The bus width is the value of `bus_4bit` at acceptance.
- R12: `rsp_valid` pulses for one clock when a read completes, in a clock where `req_ready` is already high again. A write produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine idle, request taken this clock if valid |
| req_kind | input | 2 | Bit 0 = register select, bit 1 = read |
| req_wdata | input | 8 | Byte to write |
| bus_4bit | input | 1 | 1 = narrow bus on data lines 7:4 |
| rsp_valid | output | 1 | One-clock pulse at read completion |
| rsp_data | output | 8 | Byte read |
| rsp_busy | output | 1 | Bit 7 of the byte read |
| rsp_addr | output | 7 | Bits 6:0 of the byte read |
| lcd_rs | output | 1 | Register select line |
| lcd_rw | output | 1 | Direction line, high = module drives data |
| lcd_e | output | 1 | Enable strobe |
| lcd_db_out | output | 8 | Data lines driven toward the module |
| lcd_db_oe | output | 1 | Output enable for the data lines |
| lcd_db_in | input | 8 | Data lines as seen from the module |

## Verification
The end of one request and the start of the next can fall in the same clock. The response pulse of a read comes out in the very clock in which `req_ready` returns, and the bench offers its next request in that same clock. This tests that the pulse carries the old byte while the new request is latched, and that the rising-edge spacing still holds across the boundary. In the same way, the bench keeps `req_valid` high with scrambled kind, data and width all through a busy request. It then judges by the strobe count, the line values and the response that nothing of the scramble got in.

// File: rtl/lcdb_pkg.sv
// Package: shared types and helpers for the LCD bus cycle engine.
// Assumes an 8-bit data word split into two 4-bit lanes on the narrow bus.
package lcdb_pkg;

    localparam int BYTE_W   = 8;
    localparam int NIB_W    = 4;
    localparam int N_LANES  = BYTE_W / NIB_W;
    localparam int ADDR_W   = BYTE_W - 1;
    localparam int KIND_W   = 2;
    localparam int KIND_SEL = 0;   // request kind bit driving register select
    localparam int KIND_RD  = 1;   // request kind bit driving direction (1 = read)

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SETUP = 2'd1,
        PH_HIGH  = 2'd2,
        PH_HOLD  = 2'd3
    } lcdb_phase_e;

    // Larger of three counts, used to size the phase counter.
    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/lcdb_downcnt.sv
// Loadable down-counter that stops at zero.
// Assumes load_val fits in W bits; zero is high whenever the count is zero.
module lcdb_downcnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);

    logic [W-1:0] cnt_q;

    // Load takes priority; otherwise count down and rest at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Expiry flag.
    always_comb zero = (cnt_q == '0);

endmodule

// File: rtl/lcdb_lane.sv
// Data path: holds the write byte, presents the byte or the current nibble on
// the data lines, and assembles read data from one or two strobes.
// Assumes the sequencer gives a capture pulse in the last strobe-high clock.
module lcdb_lane
    import lcdb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              mode4,
    input  logic              nib_sel,
    input  logic              cap,
    input  logic [BYTE_W-1:0] db_in,
    output logic [BYTE_W-1:0] db_out,
    output logic [BYTE_W-1:0] rd_byte
);

    logic [BYTE_W-1:0] wbuf_q;
    logic [NIB_W-1:0]  rd_nib_q [N_LANES];

    // Latch the write byte when a request is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wbuf_q <= '0;
        end else if (accept) begin
            wbuf_q <= wdata;
        end
    end

    // Narrow bus: upper nibble on the first strobe, lower on the second.
    always_comb begin
        if (mode4) begin
            db_out = {(nib_sel ? wbuf_q[NIB_W-1:0] : wbuf_q[BYTE_W-1:NIB_W]),
                      {NIB_W{1'b0}}};
        end else begin
            db_out = wbuf_q;
        end
    end

    // One capture register per nibble lane of the result byte.
    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        // On the narrow bus lane g is filled by strobe (N_LANES-1-g).
        localparam logic FILL_SEL = (g == N_LANES - 1) ? 1'b0 : 1'b1;

        // Capture this lane from the full bus or from the upper lines.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rd_nib_q[g] <= '0;
            end else if (cap) begin
                if (!mode4) begin
                    rd_nib_q[g] <= db_in[g*NIB_W +: NIB_W];
                end else if (nib_sel == FILL_SEL) begin
                    rd_nib_q[g] <= db_in[BYTE_W-1 -: NIB_W];
                end
            end
        end

        // Place the lane in the result byte.
        always_comb rd_byte[g*NIB_W +: NIB_W] = rd_nib_q[g];
    end

endmodule

// File: rtl/lcdb_seq.sv
// Strobe sequencer: walks setup, strobe-high and hold phases once per nibble
// or byte, owns the select, direction, strobe and output-enable registers.
// Assumes all timing counts are at least 1 and fit the given counter widths.
module lcdb_seq
    import lcdb_pkg::*;
#(
    parameter int SETUP_CYC = 35,
    parameter int HIGH_CYC  = 113,
    parameter int HOLD_CYC  = 3,
    parameter int CYCLE_CYC = 250,
    parameter int PH_W      = 7,
    parameter int CYC_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [KIND_W-1:0] req_kind,
    input  logic              bus_4bit,
    output logic              req_ready,
    output logic              accept,
    input  logic              ph_zero,
    input  logic              cyc_zero,
    output logic              ph_load,
    output logic [PH_W-1:0]   ph_val,
    output logic              cyc_load,
    output logic [CYC_W-1:0]  cyc_val,
    output logic              cap,
    output logic              mode4,
    output logic              nib_sel,
    output logic              lcd_rs,
    output logic              lcd_rw,
    output logic              lcd_e,
    output logic              lcd_db_oe,
    output logic              rsp_valid
);

    lcdb_phase_e phase_q;
    logic        more;

    // A second strobe remains when the narrow bus is on its first nibble.
    always_comb more = mode4 && !nib_sel;

    // Handshake: idle is the only phase that takes a request.
    always_comb begin
        req_ready = (phase_q == PH_IDLE);
        accept    = req_ready && req_valid;
    end

    // Counter loads and the read capture pulse for the current phase.
    always_comb begin
        ph_load  = 1'b0;
        ph_val   = '0;
        cyc_load = 1'b0;
        cyc_val  = CYC_W'(CYCLE_CYC - 1);
        cap      = 1'b0;
        unique case (phase_q)
            PH_IDLE: begin
                if (req_valid) begin
                    ph_load = 1'b1;
                    ph_val  = PH_W'(SETUP_CYC - 1);
                end
            end
            PH_SETUP: begin
                if (ph_zero && cyc_zero) begin
                    ph_load  = 1'b1;
                    ph_val   = PH_W'(HIGH_CYC - 1);
                    cyc_load = 1'b1;
                end
            end
            PH_HIGH: begin
                if (ph_zero) begin
                    ph_load = 1'b1;
                    ph_val  = PH_W'(HOLD_CYC - 1);
                    cap     = lcd_rw;
                end
            end
            PH_HOLD: begin
                if (ph_zero && more) begin
                    ph_load = 1'b1;
                    ph_val  = PH_W'(SETUP_CYC - 1);
                end
            end
            default: ;
        endcase
    end

    // Phase register and pin registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q   <= PH_IDLE;
            lcd_rs    <= 1'b0;
            lcd_rw    <= 1'b0;
            lcd_e     <= 1'b0;
            lcd_db_oe <= 1'b0;
            mode4     <= 1'b0;
            nib_sel   <= 1'b0;
            rsp_valid <= 1'b0;
        end else begin
            rsp_valid <= 1'b0;
            unique case (phase_q)
                PH_IDLE: begin
                    if (req_valid) begin
                        phase_q   <= PH_SETUP;
                        lcd_rs    <= req_kind[KIND_SEL];
                        lcd_rw    <= req_kind[KIND_RD];
                        lcd_db_oe <= !req_kind[KIND_RD];
                        mode4     <= bus_4bit;
                        nib_sel   <= 1'b0;
                    end
                end
                PH_SETUP: begin
                    if (ph_zero && cyc_zero) begin
                        phase_q <= PH_HIGH;
                        lcd_e   <= 1'b1;
                    end
                end
                PH_HIGH: begin
                    if (ph_zero) begin
                        phase_q <= PH_HOLD;
                        lcd_e   <= 1'b0;
                    end
                end
                PH_HOLD: begin
                    if (ph_zero) begin
                        if (more) begin
                            phase_q <= PH_SETUP;
                            nib_sel <= 1'b1;
                        end else begin
                            phase_q   <= PH_IDLE;
                            lcd_rw    <= 1'b0;
                            lcd_db_oe <= 1'b0;
                            rsp_valid <= lcd_rw;
                        end
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/lcd_bus_engine.sv
// Top: single-access bus cycle engine for a parallel character-LCD module.
// Assumes one request in flight; timing parameters are in system clocks and
// each is at least 1. Defaults suit a 250 MHz clock.
module lcd_bus_engine
    import lcdb_pkg::*;
#(
    parameter int SETUP_CYC = 35,
    parameter int HIGH_CYC  = 113,
    parameter int HOLD_CYC  = 3,
    parameter int CYCLE_CYC = 250
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [KIND_W-1:0] req_kind,
    input  logic [BYTE_W-1:0] req_wdata,
    input  logic              bus_4bit,
    output logic              rsp_valid,
    output logic [BYTE_W-1:0] rsp_data,
    output logic              rsp_busy,
    output logic [ADDR_W-1:0] rsp_addr,
    output logic              lcd_rs,
    output logic              lcd_rw,
    output logic              lcd_e,
    output logic [BYTE_W-1:0] lcd_db_out,
    output logic              lcd_db_oe,
    input  logic [BYTE_W-1:0] lcd_db_in
);

    localparam int PH_MAX = max3(SETUP_CYC, HIGH_CYC, HOLD_CYC);
    localparam int PH_W   = $clog2(PH_MAX + 1);
    localparam int CYC_W  = $clog2(CYCLE_CYC + 1);

    logic             accept, cap, mode4, nib_sel;
    logic             ph_load, ph_zero, cyc_load, cyc_zero;
    logic [PH_W-1:0]  ph_val;
    logic [CYC_W-1:0] cyc_val;
    logic [BYTE_W-1:0] rd_byte;

    lcdb_seq #(
        .SETUP_CYC (SETUP_CYC),
        .HIGH_CYC  (HIGH_CYC),
        .HOLD_CYC  (HOLD_CYC),
        .CYCLE_CYC (CYCLE_CYC),
        .PH_W      (PH_W),
        .CYC_W     (CYC_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_kind  (req_kind),
        .bus_4bit  (bus_4bit),
        .req_ready (req_ready),
        .accept    (accept),
        .ph_zero   (ph_zero),
        .cyc_zero  (cyc_zero),
        .ph_load   (ph_load),
        .ph_val    (ph_val),
        .cyc_load  (cyc_load),
        .cyc_val   (cyc_val),
        .cap       (cap),
        .mode4     (mode4),
        .nib_sel   (nib_sel),
        .lcd_rs    (lcd_rs),
        .lcd_rw    (lcd_rw),
        .lcd_e     (lcd_e),
        .lcd_db_oe (lcd_db_oe),
        .rsp_valid (rsp_valid)
    );

    // Phase length counter (setup, strobe-high, hold).
    lcdb_downcnt #(.W(PH_W)) u_ph_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ph_load),
        .load_val (ph_val),
        .zero     (ph_zero)
    );

    // Rising-edge spacing counter, restarted at every strobe rise.
    lcdb_downcnt #(.W(CYC_W)) u_cyc_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cyc_load),
        .load_val (cyc_val),
        .zero     (cyc_zero)
    );

    lcdb_lane u_lane (
        .clk     (clk),
        .rst_n   (rst_n),
        .accept  (accept),
        .wdata   (req_wdata),
        .mode4   (mode4),
        .nib_sel (nib_sel),
        .cap     (cap),
        .db_in   (lcd_db_in),
        .db_out  (lcd_db_out),
        .rd_byte (rd_byte)
    );

    // Response view of the assembled byte.
    always_comb begin
        rsp_data = rd_byte;
        rsp_busy = rd_byte[BYTE_W-1];
        rsp_addr = rd_byte[ADDR_W-1:0];
    end

endmodule

// File: rtl/lcd_bus_engine_chk.sv
// Checker: timing and bus-ownership properties seen at the engine's pins.
// Window lengths are measured with counters so no parameter sets a delay.
module lcd_bus_engine_chk #(
    parameter int SETUP_CYC = 35,
    parameter int HIGH_CYC  = 113,
    parameter int HOLD_CYC  = 3,
    parameter int CYCLE_CYC = 250
) (
    input logic       clk,
    input logic       rst_n,
    input logic       req_ready,
    input logic       rsp_valid,
    input logic       lcd_rs,
    input logic       lcd_rw,
    input logic       lcd_e,
    input logic [7:0] lcd_db_out,
    input logic       lcd_db_oe
);

    localparam int CW = $clog2(CYCLE_CYC + SETUP_CYC + HIGH_CYC + HOLD_CYC + 2) + 1;
    localparam logic [CW-1:0] CMAX = '1;

    logic          p_rs, p_rw, p_e, p_oe;
    logic [7:0]    p_db;
    logic [CW-1:0] age_q, hi_q, lo_q, gap_q;
    logic          ctl_chg, hold_chg;

    // Change detectors against the previous clock.
    always_comb begin
        ctl_chg  = (lcd_rs != p_rs) || (lcd_rw != p_rw);
        hold_chg = ctl_chg || (lcd_db_oe && p_oe && (lcd_db_out != p_db));
    end

    // Previous-clock copies and window counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_rs <= 1'b0; p_rw <= 1'b0; p_e <= 1'b0; p_oe <= 1'b0; p_db <= '0;
            age_q <= CMAX; hi_q <= '0; lo_q <= CMAX; gap_q <= CMAX;
        end else begin
            p_rs <= lcd_rs; p_rw <= lcd_rw; p_e <= lcd_e;
            p_oe <= lcd_db_oe; p_db <= lcd_db_out;
            age_q <= ctl_chg ? CW'(1) : ((age_q == CMAX) ? age_q : age_q + 1'b1);
            hi_q  <= lcd_e ? hi_q + 1'b1 : '0;
            lo_q  <= lcd_e ? '0 : ((lo_q == CMAX) ? lo_q : lo_q + 1'b1);
            gap_q <= (lcd_e && !p_e) ? CW'(1) : ((gap_q == CMAX) ? gap_q : gap_q + 1'b1);
        end
    end

    // R1: idle state out of reset
    a_r1_reset_idle: assert property (@(posedge clk)
        $rose(rst_n) |-> (req_ready && !lcd_e && !lcd_rw && !lcd_db_oe && !rsp_valid));

    // R2: select and direction frozen while the strobe is high
    a_r2_ctl_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (lcd_e && p_e) |-> (!ctl_chg));

    // R6: control setup before the strobe rises
    a_r6_setup: assert property (@(posedge clk) disable iff (!rst_n)
        (lcd_e && !p_e) |-> (age_q >= CW'(SETUP_CYC)));

    // R7: strobe-high width
    a_r7_high_width: assert property (@(posedge clk) disable iff (!rst_n)
        (!lcd_e && p_e) |-> (hi_q == CW'(HIGH_CYC)));

    // R8: hold after the strobe falls
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!lcd_e && hold_chg) |-> (lo_q >= CW'(HOLD_CYC)));

    // R8: write data steady while the strobe is high
    a_r8_data_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (lcd_e && p_e && lcd_db_oe) |-> (lcd_db_out == p_db));

    // R9: rising-edge spacing
    a_r9_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (lcd_e && !p_e) |-> (gap_q >= CW'(CYCLE_CYC)));

    // R10: never both sides driving
    a_r10_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        lcd_db_oe |-> !lcd_rw);

    // R10: output enable already off before the direction turns to read
    a_r10_oe_before_rw: assert property (@(posedge clk) disable iff (!rst_n)
        (lcd_rw && !p_rw) |-> !p_oe);

    // R10: output enable turns on only after the direction was low
    a_r10_rw_before_oe: assert property (@(posedge clk) disable iff (!rst_n)
        (lcd_db_oe && !p_oe) |-> !p_rw);

    // R12: response in an idle clock and only one clock long
    a_r12_rsp_idle: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> req_ready);

    a_r12_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

endmodule

bind lcd_bus_engine lcd_bus_engine_chk #(
    .SETUP_CYC (SETUP_CYC),
    .HIGH_CYC  (HIGH_CYC),
    .HOLD_CYC  (HOLD_CYC),
    .CYCLE_CYC (CYCLE_CYC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .lcd_rs     (lcd_rs),
    .lcd_rw     (lcd_rw),
    .lcd_e      (lcd_e),
    .lcd_db_out (lcd_db_out),
    .lcd_db_oe  (lcd_db_oe)
);

// File: tb/lcd_bus_engine_tb.sv
// Bench: directed corners plus seeded random requests against a bus model.
module lcd_bus_engine_tb;

    localparam int SETUP_CYC = 35;
    localparam int HIGH_CYC  = 113;
    localparam int HOLD_CYC  = 3;
    localparam int CYCLE_CYC = 250;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic [1:0] req_kind = 2'b00;
    logic [7:0] req_wdata = 8'h00;
    logic       bus_4bit = 1'b0;
    logic       rsp_valid, rsp_busy;
    logic [7:0] rsp_data;
    logic [6:0] rsp_addr;
    logic       lcd_rs, lcd_rw, lcd_e, lcd_db_oe;
    logic [7:0] lcd_db_out, lcd_db_in, model_val;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // Bus model state
    logic [7:0] model_rd = 8'h00;
    logic       model_m4 = 1'b0;
    logic [7:0] junk = 8'h00;
    int         stb_n = 0;
    logic       s_rs [4];
    logic       s_rw [4];
    logic       s_oe [4];
    logic [7:0] s_db [4];
    int         overlap = 0;

    always #2 clk = ~clk;   // 250 MHz

    lcd_bus_engine #(
        .SETUP_CYC (SETUP_CYC), .HIGH_CYC (HIGH_CYC),
        .HOLD_CYC  (HOLD_CYC),  .CYCLE_CYC (CYCLE_CYC)
    ) u_dut (
        .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_ready (req_ready),
        .req_kind (req_kind), .req_wdata (req_wdata), .bus_4bit (bus_4bit),
        .rsp_valid (rsp_valid), .rsp_data (rsp_data), .rsp_busy (rsp_busy),
        .rsp_addr (rsp_addr), .lcd_rs (lcd_rs), .lcd_rw (lcd_rw), .lcd_e (lcd_e),
        .lcd_db_out (lcd_db_out), .lcd_db_oe (lcd_db_oe), .lcd_db_in (lcd_db_in)
    );

    // Module side: valid data only while the strobe is high, junk otherwise.
    always_comb begin
        if (!model_m4) model_val = model_rd;
        else if (stb_n <= 1) model_val = {model_rd[7:4], junk[3:0]};
        else model_val = {model_rd[3:0], junk[3:0]};
    end
    assign lcd_db_in = lcd_e ? model_val : junk;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Pin monitor: strobe log and timing windows, sampled at the falling clock.
    int  age = 1000000, hi = 0, lo = 1000000, gap = 1000000;
    bit  had_rise = 1'b0;
    logic p_rs = 1'b0, p_rw = 1'b0, p_e = 1'b0, p_oe = 1'b0;
    logic [7:0] p_db = 8'h00;
    always @(negedge clk) begin
        junk = 8'($urandom);
        if (rst_n) begin
            if (lcd_db_oe && lcd_rw) overlap++;
            if (lcd_rs != p_rs || lcd_rw != p_rw) age = 0; else age++;
            gap++;
            if (lcd_e && !p_e) begin
                if (stb_n < 4) begin
                    s_rs[stb_n] = lcd_rs; s_rw[stb_n] = lcd_rw;
                    s_oe[stb_n] = lcd_db_oe; s_db[stb_n] = lcd_db_out;
                end
                stb_n++;
                chk(age >= SETUP_CYC, "R6 setup before rise", age, SETUP_CYC);
                if (had_rise) chk(gap >= CYCLE_CYC, "R9 rise spacing", gap, CYCLE_CYC);
                had_rise = 1'b1;
                gap = 0;
            end
            if (lcd_e) begin
                hi++;
                if (p_e && ((lcd_db_oe && lcd_db_out != p_db) || lcd_rs != p_rs || lcd_rw != p_rw))
                    chk(1'b0, "R8 change while strobe high", lcd_db_out, p_db);
            end else if (p_e) begin
                chk(hi == HIGH_CYC, "R7 strobe width", hi, HIGH_CYC);
                hi = 0;
                lo = 0;
            end else begin
                lo++;
                if ((lcd_rs != p_rs || lcd_rw != p_rw || (lcd_db_oe && p_oe && lcd_db_out != p_db))
                    && lo < HOLD_CYC)
                    chk(1'b0, "R8 hold after fall", lo, HOLD_CYC);
            end
            p_rs = lcd_rs; p_rw = lcd_rw; p_e = lcd_e; p_oe = lcd_db_oe; p_db = lcd_db_out;
        end
    end

    // One request: offer, scramble inputs while busy, then judge at completion.
    task automatic do_txn(input logic [1:0] kind, input logic [7:0] wd,
                          input logic m4, input logic [7:0] rd);
        int nexp;
        logic [7:0] exp_db;
        model_rd = rd;
        model_m4 = m4;
        while (!req_ready) @(negedge clk);
        stb_n = 0;
        req_valid = 1'b1; req_kind = kind; req_wdata = wd; bus_4bit = m4;
        @(negedge clk);
        chk(!req_ready, "R11 ready low while busy", req_ready, 0);
        forever begin
            if (req_ready) break;
            req_valid = 1'($urandom);
            req_kind  = 2'($urandom);
            req_wdata = 8'($urandom);
            bus_4bit  = 1'($urandom);
            @(negedge clk);
        end
        req_valid = 1'b0;
        nexp = m4 ? 2 : 1;
        chk(stb_n == nexp, m4 ? "R4 strobe count" : "R3 strobe count", stb_n, nexp);
        for (int i = 0; i < nexp && i < stb_n; i++) begin
            chk(s_rs[i] == kind[0], "R2 select line", s_rs[i], kind[0]);
            chk(s_rw[i] == kind[1], "R2 direction line", s_rw[i], kind[1]);
            chk(s_oe[i] == !kind[1], "R10 output enable", s_oe[i], !kind[1]);
            if (!kind[1]) begin
                exp_db = !m4 ? wd : (i == 0 ? {wd[7:4], 4'h0} : {wd[3:0], 4'h0});
                chk(s_db[i] == exp_db, m4 ? "R4 nibble data" : "R3 byte data", s_db[i], exp_db);
            end
        end
        chk(rsp_valid == kind[1], "R12 response pulse", rsp_valid, kind[1]);
        if (kind[1]) begin
            chk(rsp_data == rd, "R5 read byte", rsp_data, rd);
            chk(rsp_busy == rd[7], "R5 busy bit", rsp_busy, rd[7]);
            chk(rsp_addr == rd[6:0], "R5 address field", rsp_addr, rd[6:0]);
        end
    endtask

    initial begin
        int unsigned seed;
        seed = $urandom(32'd7211);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !lcd_e && !lcd_rw && !lcd_db_oe && !rsp_valid,
            "R1 reset state", {req_ready, lcd_e, lcd_rw, lcd_db_oe, rsp_valid}, 5'b10000);
        // Directed corners
        do_txn(2'b00, 8'h38, 1'b0, 8'h00);   // instruction write, 8-bit
        do_txn(2'b01, 8'hA5, 1'b0, 8'h00);   // data write, 8-bit
        do_txn(2'b00, 8'h28, 1'b1, 8'h00);   // instruction write, 4-bit
        do_txn(2'b01, 8'h5C, 1'b1, 8'h00);   // data write, 4-bit
        do_txn(2'b10, 8'h00, 1'b0, 8'h8F);   // status read, busy set
        do_txn(2'b10, 8'h00, 1'b1, 8'h3A);   // status read 4-bit, busy clear
        do_txn(2'b11, 8'h00, 1'b1, 8'hC3);   // data read 4-bit
        do_txn(2'b11, 8'h00, 1'b0, 8'h00);
        do_txn(2'b10, 8'h00, 1'b1, 8'hFF);
        do_txn(2'b01, 8'hFF, 1'b1, 8'h00);   // write right after read
        // Seeded random mix
        for (int k = 0; k < 40; k++) begin
            do_txn(2'($urandom), 8'($urandom), 1'($urandom), 8'($urandom));
        end
        repeat (4) @(negedge clk);
        chk(overlap == 0, "R10 drive overlap clocks", overlap, 0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule